// File: doc/BRIEF.md
# Quad Wiper Register Bank

This block holds the digital state of four potentiometer channels. Each channel has one volatile 8-bit wiper position and four 8-bit persistent setting slots. The wiper position drives a tap-select output: 0x00 selects the tap closest to the low end and 0xFF the tap closest to the high end, which gives 256 positions. A host issues one command per cycle on a simple command port. The command picks a channel, a slot and an operation. The operations are: write or read the wiper, write or read a slot, copy a slot into the wiper, copy the wiper into a slot, and step the wiper by one position.

Writes to a slot stand in for a slow non-volatile write. The slots live in a synchronous RAM. Each slot write holds the block busy for a configurable number of clock ticks, and commands presented during that time are refused. An active-low protect input blocks every slot write, while wiper-only commands still go through. After each reset the block restores the wipers by reading slot 0 of each channel in turn. The slots are not cleared by reset.

Top module: `wiper_bank`

## Requirements
- R1: After reset is released, busy stays high for N_CH+1 cycles, counting the cycle in which reset falls. When busy drops, each channel's wiper_pos equals that channel's slot 0.
- R2: An accepted wiper-write command (op code 0) sets the selected channel's wiper_pos to cmd_data on the clock edge that accepts it. The other channels do not change.
- R3: Step-up (op 6) and step-down (op 7) move the wiper by exactly one position on the accepting edge. A step-up at 0xFF stays at 0xFF, and a step-down at 0x00 stays at 0x00.
- R4: Slot-to-wiper (op 4) loads slot cmd_reg of the channel into its wiper one cycle after the accepting edge.
- R5: Slot-write (op 2) stores cmd_data. Slot-read (op 3) raises rd_valid for one cycle, with the slot value on rd_data, one cycle after the acknowledge.
- R6: Wiper-to-slot (op 5) stores the channel's current wiper value into slot cmd_reg.
- R7: After a slot-write or wiper-to-slot command is accepted, busy is high for exactly BUSY_TICKS cycles.
- R8: Every presented command gets cmd_ack the next cycle. A command presented while busy gets cmd_err with its ack and changes no wiper and no slot.
- R9: While wp_n is low, ops 2 and 5 are answered with cmd_err and leave the slots unchanged and busy low. Ops 0, 6 and 7 still take effect.
- R10: Slot contents survive a reset. After each reset every wiper is reloaded from its channel's slot 0.
- R11: Wiper-read (op 1) returns the channel's wiper value on rd_data with rd_valid one cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code (see requirements) |
| cmd_ch | input | $clog2(N_CH) | Channel select |
| cmd_reg | input | $clog2(N_REG) | Slot select |
| cmd_data | input | WIDTH | Write data |
| wp_n | input | 1 | Active-low slot write protect |
| cmd_ack | output | 1 | Command seen, one cycle after presentation |
| cmd_err | output | 1 | Command refused, valid with cmd_ack |
| rd_valid | output | 1 | Read data present |
| rd_data | output | WIDTH | Read result |
| busy | output | 1 | Recall, read/load or slot write in progress |
| wiper_pos | output | N_CH*WIDTH | Wiper positions, channel 0 in the low byte |

## Verification
All sixteen slots are written with distinct arithmetic patterns and read back. Each slot is then copied into its wiper, so that a wrong channel or slot index shows up as a wrong value. Step commands are applied at 0xFE, 0xFF, 0x01, 0x00 and at a mid-scale carry, which separates a correct saturating step from wrapping or a step by more than one. Commands are sent in the middle of a busy window and with protect low, to show that refusals leave both wipers and slots untouched. A reset after slot writes checks that the recall picks up the new slot 0 values and not the power-on contents.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [2:0] {
    OP_WR_WIP = 3'd0,
    OP_RD_WIP = 3'd1,
    OP_WR_DAT = 3'd2,
    OP_RD_DAT = 3'd3,
    OP_LOAD   = 3'd4,
    OP_SAVE   = 3'd5,
    OP_UP     = 3'd6,
    OP_DN     = 3'd7
  } wb_op_e;

  typedef enum logic [1:0] {
    ST_RECALL  = 2'd0,
    ST_IDLE    = 2'd1,
    ST_PEND    = 2'd2,
    ST_PERSIST = 2'd3
  } wb_state_e;
endpackage

// File: rtl/wb_store.sv
module wb_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  parameter int SEED  = 53,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // power-on contents model the factory state of the persistent slots
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = WIDTH'(SEED + 29 * i);
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wb_wiper.sv
module wb_wiper #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             up,
  input  logic             dn,
  output logic [WIDTH-1:0] pos
);
  localparam logic [WIDTH-1:0] TOP = '1;
  localparam logic [WIDTH-1:0] BOT = '0;

  always_ff @(posedge clk) begin
    if (rst)                   pos <= BOT;
    else if (ld)               pos <= ld_val;
    else if (up && pos != TOP) pos <= pos + 1'b1;
    else if (dn && pos != BOT) pos <= pos - 1'b1;
  end

  p_sat_top_r3: assert property (@(posedge clk) disable iff (rst)
    (!ld && up && pos == TOP) |=> pos == TOP);
  p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
    (!ld && up && pos != TOP) |=> pos == $past(pos) + 1'b1);
  p_step_dn_r3: assert property (@(posedge clk) disable iff (rst)
    (!ld && !up && dn && pos != BOT) |=> pos == $past(pos) - 1'b1);
  p_sat_bot_r3: assert property (@(posedge clk) disable iff (rst)
    (!ld && !up && dn && pos == BOT) |=> pos == BOT);
endmodule

// File: rtl/wb_ctrl.sv
module wb_ctrl
  import wb_pkg::*;
#(
  parameter int N_CH       = 4,
  parameter int N_REG      = 4,
  parameter int WIDTH      = 8,
  parameter int BUSY_TICKS = 500000,
  localparam int CH_W      = $clog2(N_CH),
  localparam int RG_W      = $clog2(N_REG),
  localparam int AW        = CH_W + RG_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  logic [2:0]            cmd_op,
  input  logic [CH_W-1:0]       cmd_ch,
  input  logic [RG_W-1:0]       cmd_reg,
  input  logic [WIDTH-1:0]      cmd_data,
  input  logic                  wp_n,
  input  logic [N_CH*WIDTH-1:0] wip_bus,
  input  logic [WIDTH-1:0]      ram_q,
  output logic                  ram_we,
  output logic [AW-1:0]         ram_waddr,
  output logic [WIDTH-1:0]      ram_wdata,
  output logic [AW-1:0]         ram_raddr,
  output logic [N_CH-1:0]       wip_ld,
  output logic [WIDTH-1:0]      wip_ld_val,
  output logic [N_CH-1:0]       wip_up,
  output logic [N_CH-1:0]       wip_dn,
  output logic                  cmd_ack,
  output logic                  cmd_err,
  output logic                  rd_valid,
  output logic [WIDTH-1:0]      rd_data,
  output logic                  busy
);
  localparam int CNT_W = $clog2(BUSY_TICKS + 1);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CH - 1);

  wb_state_e        state;
  wb_op_e           op, pend_op;
  logic [CH_W-1:0]  rc_idx, rc_ch, pend_ch;
  logic             rc_vld;
  logic [CNT_W-1:0] cnt;
  logic [WIDTH-1:0] snap, wip_sel;
  logic             is_persist, take, refuse;

  assign op         = wb_op_e'(cmd_op);
  assign is_persist = (op == OP_WR_DAT) || (op == OP_SAVE);
  assign take       = cmd_valid && (state == ST_IDLE) && !(is_persist && !wp_n);
  assign refuse     = cmd_valid && !take;
  assign wip_sel    = wip_bus[cmd_ch*WIDTH +: WIDTH];
  assign busy       = (state != ST_IDLE);

  // RAM port steering
  assign ram_raddr = (state == ST_RECALL) ? {rc_idx, RG_W'(0)} : {cmd_ch, cmd_reg};
  assign ram_we    = take && is_persist;
  assign ram_waddr = {cmd_ch, cmd_reg};
  assign ram_wdata = (op == OP_SAVE) ? wip_sel : cmd_data;

  // wiper update strobes
  always_comb begin
    wip_ld     = '0;
    wip_up     = '0;
    wip_dn     = '0;
    wip_ld_val = cmd_data;
    if (state == ST_RECALL && rc_vld) begin
      wip_ld[rc_ch] = 1'b1;
      wip_ld_val    = ram_q;
    end else if (state == ST_PEND && pend_op == OP_LOAD) begin
      wip_ld[pend_ch] = 1'b1;
      wip_ld_val      = ram_q;
    end else if (take) begin
      case (op)
        OP_WR_WIP: wip_ld[cmd_ch] = 1'b1;
        OP_UP:     wip_up[cmd_ch] = 1'b1;
        OP_DN:     wip_dn[cmd_ch] = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RECALL;
      rc_idx   <= '0;
      rc_ch    <= '0;
      rc_vld   <= 1'b0;
      cnt      <= '0;
      cmd_ack  <= 1'b0;
      cmd_err  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      pend_op  <= OP_RD_WIP;
      pend_ch  <= '0;
      snap     <= '0;
    end else begin
      cmd_ack  <= cmd_valid;
      cmd_err  <= refuse;
      rd_valid <= 1'b0;
      case (state)
        ST_RECALL: begin
          rc_idx <= rc_idx + 1'b1;
          rc_ch  <= rc_idx;
          rc_vld <= 1'b1;
          if (rc_vld && rc_ch == LAST_CH) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (take) begin
            case (op)
              OP_RD_WIP, OP_RD_DAT, OP_LOAD: begin
                state   <= ST_PEND;
                pend_op <= op;
                pend_ch <= cmd_ch;
                snap    <= wip_sel;
              end
              OP_WR_DAT, OP_SAVE: begin
                state <= ST_PERSIST;
                cnt   <= CNT_W'(BUSY_TICKS - 1);
              end
              default: ;
            endcase
          end
        end
        ST_PEND: begin
          state <= ST_IDLE;
          if (pend_op != OP_LOAD) begin
            rd_valid <= 1'b1;
            rd_data  <= (pend_op == OP_RD_DAT) ? ram_q : snap;
          end
        end
        ST_PERSIST: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_recall_busy_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> busy);
  p_rd_after_ack_r5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(cmd_ack) && !$past(cmd_err)));
  p_persist_busy_r7: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> busy);
  p_busy_refuse_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && busy) |=> (cmd_ack && cmd_err));
  p_wp_block_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !wp_n && (cmd_op == 3'd2 || cmd_op == 3'd5)) |=> cmd_err);
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank #(
  parameter int N_CH       = 4,
  parameter int N_REG      = 4,
  parameter int WIDTH      = 8,
  parameter int BUSY_TICKS = 500000,
  parameter int DR_SEED    = 53
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_valid,
  input  logic [2:0]                 cmd_op,
  input  logic [$clog2(N_CH)-1:0]    cmd_ch,
  input  logic [$clog2(N_REG)-1:0]   cmd_reg,
  input  logic [WIDTH-1:0]           cmd_data,
  input  logic                       wp_n,
  output logic                       cmd_ack,
  output logic                       cmd_err,
  output logic                       rd_valid,
  output logic [WIDTH-1:0]           rd_data,
  output logic                       busy,
  output logic [N_CH*WIDTH-1:0]      wiper_pos
);
  localparam int CH_W  = $clog2(N_CH);
  localparam int RG_W  = $clog2(N_REG);
  localparam int AW    = CH_W + RG_W;
  localparam int DEPTH = N_CH * N_REG;

  logic             ram_we;
  logic [AW-1:0]    ram_waddr, ram_raddr;
  logic [WIDTH-1:0] ram_wdata, ram_q, wip_ld_val;
  logic [N_CH-1:0]  wip_ld, wip_up, wip_dn;

  wb_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .SEED(DR_SEED)) u_store (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_q)
  );

  wb_ctrl #(.N_CH(N_CH), .N_REG(N_REG), .WIDTH(WIDTH), .BUSY_TICKS(BUSY_TICKS)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ch(cmd_ch), .cmd_reg(cmd_reg), .cmd_data(cmd_data), .wp_n(wp_n),
    .wip_bus(wiper_pos), .ram_q(ram_q), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .ram_raddr(ram_raddr), .wip_ld(wip_ld),
    .wip_ld_val(wip_ld_val), .wip_up(wip_up), .wip_dn(wip_dn),
    .cmd_ack(cmd_ack), .cmd_err(cmd_err), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    wb_wiper #(.WIDTH(WIDTH)) u_wiper (
      .clk(clk), .rst(rst), .ld(wip_ld[g]), .ld_val(wip_ld_val),
      .up(wip_up[g]), .dn(wip_dn[g]), .pos(wiper_pos[g*WIDTH +: WIDTH])
    );
  end
endmodule

// File: tb/tb_wiper_bank.sv
module tb_wiper_bank;
  localparam int BT   = 6;
  localparam int SEED = 53;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_ch = '0;
  logic [1:0] cmd_reg = '0;
  logic [7:0] cmd_data = '0;
  logic       wp_n = 1'b1;
  logic       cmd_ack, cmd_err, rd_valid, busy;
  logic [7:0] rd_data;
  logic [31:0] wiper_pos;

  int tests = 0;
  int fails = 0;
  logic [7:0] em [16];
  logic [7:0] ew [4];

  always #10 clk = ~clk;

  wiper_bank #(.BUSY_TICKS(BT), .DR_SEED(SEED)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ch(cmd_ch), .cmd_reg(cmd_reg), .cmd_data(cmd_data), .wp_n(wp_n),
    .cmd_ack(cmd_ack), .cmd_err(cmd_err), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy), .wiper_pos(wiper_pos)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_wipers(input string req);
    for (int c = 0; c < 4; c++)
      check($sformatf("%s wiper%0d", req, c), wiper_pos[c*8 +: 8], ew[c]);
  endtask

  // starts and ends at a falling edge; returns at the cycle showing the ack
  task automatic send(input logic [2:0] op, input int ch, input int rg,
                      input logic [7:0] d, input logic exp_err, input string req);
    cmd_valid = 1'b1; cmd_op = op; cmd_ch = 2'(ch); cmd_reg = 2'(rg); cmd_data = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check({req, " ack"}, cmd_ack, 1);
    check({req, " err"}, cmd_err, exp_err);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic count_busy(input int exp, input string req);
    int n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check({req, " busy cycles"}, n, exp);
  endtask

  task automatic read_slot(input int ch, input int rg, input string req);
    send(3'd3, ch, rg, 8'h00, 1'b0, req);
    @(negedge clk);
    check({req, " rd_valid"}, rd_valid, 1);
    check($sformatf("%s slot %0d/%0d", req, ch, rg), rd_data, em[ch*4+rg]);
    wait_idle();
  endtask

  task automatic do_reset(input string req);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check({req, " ack low in reset"}, cmd_ack, 0);
    check({req, " rd_valid low in reset"}, rd_valid, 0);
    check({req, " busy in reset"}, busy, 1);
    rst = 1'b0;
    count_busy(5, req);
    for (int c = 0; c < 4; c++) ew[c] = em[c*4];
    check_wipers(req);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) em[i] = 8'(SEED + 29 * i);
    @(negedge clk);
    // R1 power-up recall
    do_reset("R1");

    // R2 direct wiper writes
    for (int c = 0; c < 4; c++) begin
      send(3'd0, c, 0, 8'(c * 64 + 19), 1'b0, "R2");
      ew[c] = 8'(c * 64 + 19);
      check_wipers("R2");
    end

    // R11 wiper reads
    for (int c = 0; c < 4; c++) begin
      send(3'd1, c, 0, 8'h00, 1'b0, "R11");
      @(negedge clk);
      check("R11 rd_valid", rd_valid, 1);
      check("R11 rd_data", rd_data, ew[c]);
      wait_idle();
    end

    // R5/R7 write all slots, then read back
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v = 8'((i * 37 + 5) ^ 8'hA0);
      send(3'd2, i / 4, i % 4, v, 1'b0, "R5");
      em[i] = v;
      count_busy(BT, "R7");
    end
    check_wipers("R5 wipers kept");
    for (int i = 0; i < 16; i++) read_slot(i / 4, i % 4, "R5");

    // R4 slot-to-wiper for every slot
    for (int i = 0; i < 16; i++) begin
      send(3'd4, i / 4, i % 4, 8'h00, 1'b0, "R4");
      @(negedge clk);
      ew[i / 4] = em[i];
      check_wipers("R4");
      wait_idle();
    end

    // R3 steps and saturation
    send(3'd0, 0, 0, 8'hFE, 1'b0, "R3"); ew[0] = 8'hFE;
    send(3'd6, 0, 0, 8'h00, 1'b0, "R3"); ew[0] = 8'hFF; check_wipers("R3 up");
    send(3'd6, 0, 0, 8'h00, 1'b0, "R3"); check_wipers("R3 top sat");
    send(3'd0, 0, 0, 8'h01, 1'b0, "R3"); ew[0] = 8'h01;
    send(3'd7, 0, 0, 8'h00, 1'b0, "R3"); ew[0] = 8'h00; check_wipers("R3 dn");
    send(3'd7, 0, 0, 8'h00, 1'b0, "R3"); check_wipers("R3 bot sat");
    send(3'd0, 1, 0, 8'h7F, 1'b0, "R3"); ew[1] = 8'h7F;
    send(3'd6, 1, 0, 8'h00, 1'b0, "R3"); ew[1] = 8'h80; check_wipers("R3 carry");
    send(3'd7, 1, 0, 8'h00, 1'b0, "R3"); ew[1] = 8'h7F; check_wipers("R3 borrow");

    // R6 wiper-to-slot
    send(3'd0, 1, 0, 8'h5A, 1'b0, "R6"); ew[1] = 8'h5A;
    send(3'd5, 1, 3, 8'h00, 1'b0, "R6"); em[7] = 8'h5A;
    count_busy(BT, "R7 save");
    read_slot(1, 3, "R6");

    // R8 refusal while busy
    send(3'd2, 2, 1, 8'hC3, 1'b0, "R8"); em[9] = 8'hC3;
    send(3'd0, 2, 0, 8'h99, 1'b1, "R8 wiper while busy");
    check_wipers("R8 wiper unchanged");
    send(3'd2, 2, 2, 8'h77, 1'b1, "R8 slot while busy");
    wait_idle();
    read_slot(2, 1, "R8");
    read_slot(2, 2, "R8 refused slot");

    // R9 write protect
    wp_n = 1'b0;
    @(negedge clk);
    send(3'd2, 3, 0, 8'h12, 1'b1, "R9 slot write");
    check("R9 busy stays low", busy, 0);
    send(3'd5, 3, 1, 8'h00, 1'b1, "R9 save");
    check("R9 busy stays low save", busy, 0);
    send(3'd0, 3, 0, 8'h44, 1'b0, "R9 wiper write"); ew[3] = 8'h44;
    send(3'd6, 3, 0, 8'h00, 1'b0, "R9 step"); ew[3] = 8'h45;
    check_wipers("R9");
    read_slot(3, 0, "R9");
    read_slot(3, 1, "R9");
    wp_n = 1'b1;

    // R10 slots persist across reset, wipers reload
    send(3'd2, 2, 0, 8'hA5, 1'b0, "R10"); em[8] = 8'hA5;
    wait_idle();
    do_reset("R10");
    read_slot(1, 3, "R10");
    read_slot(2, 0, "R10");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule